// File: doc/BRIEF.md
# Double-Late-Write Synchronous SRAM Core

This block is a synchronous, single-data-rate memory with a read path and a write path that share one command slot per clock. On every rising edge it takes in a command: enable, read-or-write select, an address and a burst length. A read puts its word on the output register on the next rising edge, and a valid flag stays high for that one cycle. A write does not carry its data with the command. The data and its per-lane byte enables arrive on the second rising edge after the command.

Writes that already have their data wait in a two-entry posted buffer and move into the array only when a later write needs the space. They retire oldest first. A read looks at the array, both buffered entries and any write whose data is arriving on the same edge. For each 9-bit lane it picks the newest of these, so read-after-write order is kept even for back-to-back traffic.

A command can ask for 1 to 4 beats. The beats after the first are issued internally on the following cycles, at addresses that step upward within an aligned group of four words and wrap around. While such a burst is running, the command inputs are ignored. The depth is a parameter and is kept small by default.

Top module: `dlw_sram`

## Requirements
- R1: When `cmd_en` is low at a rising edge and no burst beat is pending, that edge starts no operation: no read data is launched for it and no write data is later taken for it.
- R2: A read issued at rising edge k drives `rd_data` and raises `rd_oe` from edge k+1 for exactly one cycle.
- R3: For a write issued at edge k, `wr_data` and `wr_be` are sampled at edge k+2 and at no other edge.
- R4: `rd_oe` is low in every cycle whose closing edge samples write data.
- R5: A read returns the newest value of its address. This includes data sampled at the same edge the read data is launched and data still held in the posted buffer.
- R6: Bit i of `wr_be` governs lane i (bits 9i+8 down to 9i) of the 36-bit word. Lanes whose enable is 0 keep their previous value, and a read takes each lane from the newest write that enabled it.
- R7: `cmd_len` holds the beat count minus one (0 to 3). Beats run on consecutive edges. Each later beat increments the low two address bits modulo 4 and keeps the upper bits.
- R8: On edges that carry a burst continuation beat, `cmd_en`, `cmd_wr`, `cmd_addr` and `cmd_len` are ignored, and each beat keeps the direction of the first beat.
- R9: At most two written words are held pending. They retire to the array in issue order, and the oldest one leaves only when a new write's data is sampled.
- R10: While `rst_n` is low and after its release, `rd_oe` is low until a read has been issued.
- R11: Deselected cycles still sample the data of earlier writes, and that data is visible to later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Command enable |
| cmd_wr | input | 1 | 1 selects write, 0 selects read |
| cmd_addr | input | AW | Word address of the first beat |
| cmd_len | input | 2 | Beats minus one (0..3) |
| wr_data | input | 36 | Write data, sampled two edges after its command |
| wr_be | input | 4 | Per-lane write enables, sampled with `wr_data` |
| rd_data | output | 36 | Registered read data |
| rd_oe | output | 1 | High in the cycle `rd_data` holds read data |

## Verification
Traffic is packed onto a handful of addresses so that reads land on writes at every distance. That includes a read issued one cycle after a write to the same word, when the data is still on the input pins. A design that forwarded only from the buffer would return stale words there. A design that ignored per-lane enables during the merge would mix lanes wrongly after two partial writes to one address. Long bursts start at every low-address offset and carry random command inputs meant to be ignored; a wrong wrap would corrupt neighbouring groups, and a leaky command path would start unexpected operations. Random byte enables and data sit on the write pins every cycle, so sampling write data one edge early or late corrupts the stored words at once.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

    localparam int unsigned LANE_BITS = 9;
    localparam int unsigned LANE_CNT  = 4;
    localparam int unsigned BURST_MAX = 4;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

endpackage

// File: rtl/dlw_seq.sv
// Command capture and internal burst sequencing: one operation per edge.
module dlw_seq
    import dlw_pkg::*;
#(
    parameter int unsigned AW   = 6,
    parameter int unsigned BMAX = BURST_MAX,
    localparam int unsigned OW  = $clog2(BMAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_en,
    input  logic           cmd_wr,
    input  logic [AW-1:0]  cmd_addr,
    input  logic [OW-1:0]  cmd_len,
    output op_kind_e       op_kind_o,
    output logic [AW-1:0]  op_addr_o,
    output logic           busy_o
);

    typedef struct packed {
        op_kind_e      kind;
        logic [AW-1:0] addr;
        logic [OW-1:0] rem;
        logic [AW-1:0] nxt;
        op_kind_e      bkind;
    } seq_st_t;

    seq_st_t st_d, st_q;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] a);
        logic [AW-1:0] r;
        r          = a;
        r[OW-1:0]  = a[OW-1:0] + 1'b1;
        return r;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.kind = OP_IDLE;
        if (st_q.rem != '0) begin
            st_d.kind = st_q.bkind;
            st_d.addr = st_q.nxt;
            st_d.nxt  = wrap_inc(st_q.nxt);
            st_d.rem  = st_q.rem - 1'b1;
        end else if (cmd_en) begin
            st_d.kind  = cmd_wr ? OP_WRITE : OP_READ;
            st_d.addr  = cmd_addr;
            st_d.nxt   = wrap_inc(cmd_addr);
            st_d.rem   = cmd_len;
            st_d.bkind = cmd_wr ? OP_WRITE : OP_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign op_kind_o = st_q.kind;
    assign op_addr_o = st_q.addr;
    assign busy_o    = (st_q.rem != '0);

endmodule

// File: rtl/dlw_wbuf.sv
// Posted-write buffer: entry 0 is the oldest; retires only on a new capture.
module dlw_wbuf #(
    parameter int unsigned AW = 6,
    parameter int unsigned NL = 4,
    parameter int unsigned LW = 9,
    parameter int unsigned NE = 2,
    localparam int unsigned DW = NL * LW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic [AW-1:0]          cap_addr,
    input  logic [DW-1:0]          cap_data,
    input  logic [NL-1:0]          cap_be,
    output logic [NE-1:0]          ent_vld,
    output logic [NE-1:0][AW-1:0]  ent_addr,
    output logic [NE-1:0][DW-1:0]  ent_data,
    output logic [NE-1:0][NL-1:0]  ent_be,
    output logic                   ret_en,
    output logic [AW-1:0]          ret_addr,
    output logic [DW-1:0]          ret_data,
    output logic [NL-1:0]          ret_be
);

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [NL-1:0] be;
    } wb_ent_t;

    typedef struct packed {
        wb_ent_t [NE-1:0] ent;
    } wb_st_t;

    wb_st_t  st_d, st_q;
    wb_ent_t incoming;
    wb_ent_t leaving;

    always_comb begin
        int unsigned slot;
        st_d          = st_q;
        incoming.vld  = 1'b1;
        incoming.addr = cap_addr;
        incoming.data = cap_data;
        incoming.be   = cap_be;
        leaving       = '0;
        slot          = 0;
        if (cap_en) begin
            if (st_q.ent[NE-1].vld) begin
                leaving = st_q.ent[0];
                for (int i = 0; i < NE - 1; i++) begin
                    st_d.ent[i] = st_q.ent[i+1];
                end
                st_d.ent[NE-1] = incoming;
            end else begin
                for (int i = NE - 1; i >= 0; i--) begin
                    if (!st_q.ent[i].vld) slot = i;
                end
                st_d.ent[slot] = incoming;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar e = 0; e < NE; e++) begin : g_ent
        assign ent_vld[e]  = st_q.ent[e].vld;
        assign ent_addr[e] = st_q.ent[e].addr;
        assign ent_data[e] = st_q.ent[e].data;
        assign ent_be[e]   = st_q.ent[e].be;
    end

    assign ret_en   = leaving.vld;
    assign ret_addr = leaving.addr;
    assign ret_data = leaving.data;
    assign ret_be   = leaving.be;

endmodule

// File: rtl/dlw_fwd.sv
// Per-lane merge: sources ordered oldest (index 0) to newest override the array word.
module dlw_fwd #(
    parameter int unsigned AW = 6,
    parameter int unsigned NL = 4,
    parameter int unsigned LW = 9,
    parameter int unsigned NS = 3,
    localparam int unsigned DW = NL * LW
) (
    input  logic [AW-1:0]          rd_addr,
    input  logic [DW-1:0]          arr_word,
    input  logic [NS-1:0]          src_vld,
    input  logic [NS-1:0][AW-1:0]  src_addr,
    input  logic [NS-1:0][DW-1:0]  src_data,
    input  logic [NS-1:0][NL-1:0]  src_be,
    output logic [DW-1:0]          merged
);

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0] lane_w;
        always_comb begin
            lane_w = arr_word[l*LW +: LW];
            for (int s = 0; s < NS; s++) begin
                if (src_vld[s] && (src_addr[s] == rd_addr) && src_be[s][l]) begin
                    lane_w = src_data[s][l*LW +: LW];
                end
            end
        end
        assign merged[l*LW +: LW] = lane_w;
    end

endmodule

// File: rtl/dlw_array.sv
// Storage: one memory per lane, asynchronous read, lane-enabled synchronous write.
module dlw_array #(
    parameter int unsigned AW = 6,
    parameter int unsigned NL = 4,
    parameter int unsigned LW = 9,
    localparam int unsigned DEPTH = 1 << AW,
    localparam int unsigned DW    = NL * LW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [NL-1:0] wbe,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [LW-1:0] mem_q [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wbe[l]) mem_q[waddr] <= wdata[l*LW +: LW];
        end
        assign rdata[l*LW +: LW] = mem_q[raddr];
    end

endmodule

// File: rtl/dlw_sram.sv
module dlw_sram
    import dlw_pkg::*;
#(
    parameter int unsigned AW   = 6,
    parameter int unsigned LW   = LANE_BITS,
    parameter int unsigned NL   = LANE_CNT,
    parameter int unsigned BMAX = BURST_MAX,
    localparam int unsigned DW  = NL * LW,
    localparam int unsigned OW  = $clog2(BMAX),
    localparam int unsigned NB  = 2,
    localparam int unsigned NS  = NB + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_en,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    input  logic [OW-1:0] cmd_len,
    input  logic [DW-1:0] wr_data,
    input  logic [NL-1:0] wr_be,
    output logic [DW-1:0] rd_data,
    output logic          rd_oe
);

    typedef struct packed {
        logic          op2_wr;
        logic [AW-1:0] op2_addr;
        logic          rd_oe;
        logic [DW-1:0] rd_data;
    } top_st_t;

    top_st_t st_d, st_q;

    op_kind_e               op1_kind;
    logic [AW-1:0]          op1_addr;
    logic                   seq_busy;
    logic [NB-1:0]          buf_vld;
    logic [NB-1:0][AW-1:0]  buf_addr;
    logic [NB-1:0][DW-1:0]  buf_data;
    logic [NB-1:0][NL-1:0]  buf_be;
    logic                   ret_en;
    logic [AW-1:0]          ret_addr;
    logic [DW-1:0]          ret_data;
    logic [NL-1:0]          ret_be;
    logic [DW-1:0]          arr_word;
    logic [DW-1:0]          fwd_word;

    dlw_seq #(.AW(AW), .BMAX(BMAX)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_en    (cmd_en),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .op_kind_o (op1_kind),
        .op_addr_o (op1_addr),
        .busy_o    (seq_busy)
    );

    dlw_wbuf #(.AW(AW), .NL(NL), .LW(LW), .NE(NB)) wbuf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (st_q.op2_wr),
        .cap_addr (st_q.op2_addr),
        .cap_data (wr_data),
        .cap_be   (wr_be),
        .ent_vld  (buf_vld),
        .ent_addr (buf_addr),
        .ent_data (buf_data),
        .ent_be   (buf_be),
        .ret_en   (ret_en),
        .ret_addr (ret_addr),
        .ret_data (ret_data),
        .ret_be   (ret_be)
    );

    dlw_array #(.AW(AW), .NL(NL), .LW(LW)) array_i (
        .clk   (clk),
        .we    (ret_en),
        .waddr (ret_addr),
        .wdata (ret_data),
        .wbe   (ret_be),
        .raddr (op1_addr),
        .rdata (arr_word)
    );

    dlw_fwd #(.AW(AW), .NL(NL), .LW(LW), .NS(NS)) fwd_i (
        .rd_addr  (op1_addr),
        .arr_word (arr_word),
        .src_vld  ({st_q.op2_wr, buf_vld}),
        .src_addr ({st_q.op2_addr, buf_addr}),
        .src_data ({wr_data, buf_data}),
        .src_be   ({wr_be, buf_be}),
        .merged   (fwd_word)
    );

    always_comb begin
        st_d          = st_q;
        st_d.op2_wr   = (op1_kind == OP_WRITE);
        st_d.op2_addr = op1_addr;
        st_d.rd_oe    = (op1_kind == OP_READ);
        if (op1_kind == OP_READ) st_d.rd_data = fwd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;
    assign rd_oe   = st_q.rd_oe;

endmodule

// File: rtl/dlw_sram_chk.sv
module dlw_sram_chk
    import dlw_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned OW = 2,
    parameter int unsigned NB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_en,
    input op_kind_e      op1_kind,
    input logic [AW-1:0] op1_addr,
    input logic          seq_busy,
    input logic          op2_wr,
    input logic          rd_oe,
    input logic [NB-1:0] buf_vld
);

    logic [OW-1:0]    low_inc_q;
    logic [AW-OW-1:0] hi_q;
    logic [NB:0]      vld_plus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_inc_q <= '0;
            hi_q      <= '0;
        end else begin
            low_inc_q <= op1_addr[OW-1:0] + 1'b1;
            hi_q      <= op1_addr[AW-1:OW];
        end
    end

    assign vld_plus = {1'b0, buf_vld} + 1'b1;

    AST_IDLE_NO_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_en && !seq_busy) |=> (op1_kind == OP_IDLE)); // R1
    AST_NO_SPURIOUS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_kind != OP_READ) |=> !rd_oe); // R1
    AST_READ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_kind == OP_READ) |=> rd_oe); // R2
    AST_WDATA_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (op1_kind == OP_WRITE) |=> op2_wr); // R3
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        op2_wr |-> !rd_oe); // R4
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> ((op1_addr[OW-1:0] == low_inc_q) && (op1_addr[AW-1:OW] == hi_q))); // R7
    AST_BURST_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |=> (op1_kind == $past(op1_kind))); // R8
    AST_BUF_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld_plus)); // R9

endmodule

bind dlw_sram dlw_sram_chk #(.AW(AW), .OW(OW), .NB(NB)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (cmd_en),
    .op1_kind (op1_kind),
    .op1_addr (op1_addr),
    .seq_busy (seq_busy),
    .op2_wr   (st_q.op2_wr),
    .rd_oe    (rd_oe),
    .buf_vld  (buf_vld)
);

// File: tb/dlw_sram_tb_top.sv
`timescale 1ns/1ps
module dlw_sram_tb_top;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = 36;
    localparam int OW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_en = 1'b0;
    logic          cmd_wr = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [OW-1:0] cmd_len = '0;
    logic [DW-1:0] wr_data = '0;
    logic [NL-1:0] wr_be = '0;
    logic [DW-1:0] rd_data;
    logic          rd_oe;

    always #2.5 clk = ~clk;

    dlw_sram #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_wr(cmd_wr),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_data(wr_data),
        .wr_be(wr_be), .rd_data(rd_data), .rd_oe(rd_oe)
    );

    int checks = 0;
    int errors = 0;

    typedef struct { bit vld; bit wr; int addr; bit burst; } mop_t;
    mop_t           hist[$];
    logic [DW-1:0]  mem[int];
    logic [NL-1:0]  known[int];
    int             last_wr[int];
    bit             last_part[int];
    int             edge_no = 0;
    int             m_rem = 0;
    int             m_addr = 0;
    bit             m_wr = 1'b0;
    bit             exp_oe = 1'b0;
    bit             exp_known = 1'b0;
    logic [DW-1:0]  exp_data = '0;
    string          data_tag = "R2 R3";
    string          oe_tag = "R1 R11";

    task automatic fail(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        errors++;
        $display("FAIL %s: actual %h expected %h", req, act, exp);
    endtask

    // Behavioural reference, updated at each rising edge from the bench-driven inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_rem  = 0;
            exp_oe = 1'b0;
            oe_tag = "R10";
        end else begin
            mop_t n;
            int   sz;
            bit   due;
            edge_no++;
            sz = hist.size();
            // R3: write issued two edges ago takes its data now
            if (sz >= 2 && hist[sz-2].vld && hist[sz-2].wr) begin
                int a;
                a = hist[sz-2].addr;
                if (!mem.exists(a)) begin mem[a] = '0; known[a] = '0; end
                for (int l = 0; l < NL; l++) begin
                    if (wr_be[l]) begin
                        mem[a][l*LW +: LW] = wr_data[l*LW +: LW];
                        known[a][l] = 1'b1;
                    end
                end
                last_wr[a]   = edge_no;
                last_part[a] = (wr_be != '1);
            end
            // R2: read issued one edge ago is launched now
            exp_oe = 1'b0;
            if (sz >= 1 && hist[sz-1].vld && !hist[sz-1].wr) begin
                int a;
                a         = hist[sz-1].addr;
                exp_oe    = 1'b1;
                exp_known = mem.exists(a) && (known[a] == '1);
                exp_data  = exp_known ? mem[a] : '0;
                if (hist[sz-1].burst) data_tag = "R7 R8";
                else if (last_wr.exists(a) && (edge_no - last_wr[a] <= 3))
                    data_tag = last_part[a] ? "R6" : "R5 R9";
                else data_tag = "R2 R3 R11";
            end
            n.vld = 1'b0; n.wr = 1'b0; n.addr = 0; n.burst = 1'b0;
            if (m_rem > 0) begin
                n.vld = 1'b1; n.wr = m_wr; n.addr = m_addr; n.burst = 1'b1;
                m_rem--;
                m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
            end else if (cmd_en) begin
                n.vld = 1'b1; n.wr = cmd_wr; n.addr = int'(cmd_addr); n.burst = 1'b0;
                m_rem  = int'(cmd_len);
                m_wr   = cmd_wr;
                m_addr = (int'(cmd_addr) & ~3) | ((int'(cmd_addr) + 1) & 3);
            end
            hist.push_back(n);
            if (hist.size() > 3) void'(hist.pop_front());
            sz  = hist.size();
            due = (sz >= 2 && hist[sz-2].vld && hist[sz-2].wr);
            oe_tag = exp_oe ? "R2" : (due ? "R4" : "R1 R11");
        end
    end

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_oe !== exp_oe) fail(oe_tag, DW'(rd_oe), DW'(exp_oe));
            if (exp_oe && exp_known) begin
                checks++;
                if (rd_data !== exp_data) fail(data_tag, rd_data, exp_data);
            end
        end
    end

    task automatic rand_data(input bit full);
        wr_data = DW'({$urandom(), $urandom()});
        wr_be   = full ? '1 : NL'($urandom());
    endtask

    task automatic cmd(input bit en, input bit wr, input int addr, input int len, input bit full);
        @(negedge clk);
        cmd_en   = en;
        cmd_wr   = wr;
        cmd_addr = AW'(addr);
        cmd_len  = OW'(len);
        rand_data(full);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        checks++;                                  // R10: quiet in reset
        if (rd_oe !== 1'b0) fail("R10", DW'(rd_oe), '0);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;                                  // R10: quiet after release
        if (rd_oe !== 1'b0) fail("R10", DW'(rd_oe), '0);

        // Fill every word with four-beat write bursts; noise on command pins is ignored (R8).
        for (int b = 0; b < (1 << AW) / 4; b++) begin
            cmd(1'b1, 1'b1, b * 4, 3, 1'b1);
            repeat (3) cmd(1'($urandom()), 1'($urandom()), int'($urandom()), int'($urandom()), 1'b1);
        end
        repeat (2) cmd(1'b0, 1'b0, 0, 0, 1'b1);

        // R6, R5: two writes to one word, the second partial, then an immediate read.
        cmd(1'b1, 1'b1, 5, 0, 1'b1);
        cmd(1'b1, 1'b1, 5, 0, 1'b0);
        wr_be = 4'b0101;
        cmd(1'b1, 1'b0, 5, 0, 1'b0);
        cmd(1'b0, 1'b0, 0, 0, 1'b0);
        cmd(1'b1, 1'b0, 5, 0, 1'b0);
        // R11: write, deselects, then read back.
        cmd(1'b1, 1'b1, 9, 0, 1'b0);
        cmd(1'b0, 1'b0, 0, 0, 1'b0);
        cmd(1'b0, 1'b0, 0, 0, 1'b0);
        cmd(1'b1, 1'b0, 9, 0, 1'b0);
        // R7: bursts starting at every offset, wrapping inside the group.
        for (int o = 0; o < 4; o++) begin
            cmd(1'b1, 1'b0, 16 + o, 3, 1'b0);
            repeat (3) cmd(1'($urandom()), 1'($urandom()), int'($urandom()), int'($urandom()), 1'b0);
        end

        // Dense random traffic on few words, then across the whole space.
        for (int i = 0; i < 4000; i++) begin
            int addr;
            int len;
            addr = (i < 2500) ? int'($urandom() % 8) : int'($urandom() % (1 << AW));
            len  = (($urandom() % 4) == 0) ? int'($urandom() % 4) : 0;
            cmd(($urandom() % 5) != 0, 1'($urandom()), addr, len, 1'b0);
        end
        repeat (8) cmd(1'b0, 1'b0, 0, 0, 1'b0);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule